// File: doc/BRIEF.md
# Accumulator Scale, Round and Saturate Unit

This block turns a wide signed accumulator into a packed 64-bit vector of narrow lanes. Each accumulator lane is shifted right by its own amount, rounded by one of three rules and saturated into either a signed or an unsigned lane range. Byte mode handles eight 24-bit accumulator lanes and gives eight 8-bit results. Halfword mode handles four 48-bit accumulator lanes and gives four 16-bit results. The accumulator storage and the choice of the shift operand belong to the surrounding datapath. The shift vector arrives already expanded to one amount per lane.

A request is a single cycle with `in_valid` high. The packed result and an invalid-mode flag are registered and appear one cycle later, together with `out_valid`. A two-state controller drives `out_valid`. In state ST_IDLE no result is being presented. In state ST_EMIT the registered result is new in this cycle. The transition IDLE_TO_EMIT and the transition EMIT_STAY both fire on `in_valid`. The transitions EMIT_TO_IDLE and IDLE_STAY both fire when `in_valid` is low. Between requests the result registers hold their last value.

Top module: `acc_round_clamp`

## Requirements
- R1: `out_valid` is high in exactly the cycle after `in_valid` is sampled high. `res_out` and `bad_mode` change only in that cycle and hold their values otherwise.
- R2: In byte mode (`half_mode`=0), lane i takes its accumulator from `acc_in[24i+23:24i]` as a signed value and its shift from `shamt_in[8i+7:8i]` as an unsigned value. Its result goes to `res_out[8i+7:8i]`.
- R3: In halfword mode (`half_mode`=1), lane j takes its accumulator from `acc_in[48j+47:48j]` as a signed value and its shift from `shamt_in[16j+15:16j]` as an unsigned value. Its result goes to `res_out[16j+15:16j]`.
- R4: A lane whose shift is 24 or more (byte mode) or 48 or more (halfword mode) yields 0. This holds for every rounding and clamp setting.
- R5: A lane whose shift is 0 skips rounding. Its accumulator value goes straight to the clamp.
- R6: `rnd_mode[1:0]`=00 truncates toward zero: the magnitude is shifted and the sign is then restored.
- R7: `rnd_mode[1:0]`=01 rounds to the nearest value. An exact half rounds away from zero.
- R8: `rnd_mode[1:0]`=10 rounds to the nearest value. An exact half rounds to the even quotient.
- R9: `rnd_mode[2]`=0 applies an unsigned clamp. Negative values become 0, and values above 0xFF (byte mode) or 0xFFFF (halfword mode) become that maximum.
- R10: `rnd_mode[2]`=1 applies a signed clamp to 0x7F/0x80 (byte mode) or 0x7FFF/0x8000 (halfword mode). A negative accumulator never gives a positive result.
- R11: `rnd_mode` 3 or 7 sets `bad_mode` and makes every result bit 0. Every other mode clears `bad_mode`.
- R12: While `rst_n` is low, `out_valid`, `bad_mode` and `res_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| half_mode | input | 1 | 0: eight byte lanes, 1: four halfword lanes |
| rnd_mode | input | 3 | Bit 2 selects a signed clamp; bits 1:0 select the rounding rule |
| acc_in | input | 192 | Packed accumulator lanes |
| shamt_in | input | 64 | Packed per-lane right-shift amounts |
| out_valid | output | 1 | Result presented this cycle |
| res_out | output | 64 | Packed saturated lane results |
| bad_mode | output | 1 | Reserved rounding code was requested |

## Verification
The hardest case to reach from the ports is an exact tie: the bits shifted out must equal exactly half of the shifted-out weight. Ties-to-even and ties-away only differ there, and random accumulators almost never land on one. The stimulus builds these values directly as (k << s) + (1 << (s-1)) with a random sign, across every shift amount in both lane widths. Further patterns cover full-scale extremes, for saturation, and small magnitudes that pass the clamp unchanged, for the rounding itself.

// File: rtl/acc_round_clamp_pkg.sv
package acc_round_clamp_pkg;

    // Rounding rule, taken from the two low bits of the mode field.
    typedef enum logic [1:0] {
        RND_TRUNC = 2'b00,
        RND_AWAY  = 2'b01,
        RND_EVEN  = 2'b10,
        RND_BAD   = 2'b11
    } rnd_rule_e;

    // Output presentation state.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } emit_state_e;

endpackage

// File: rtl/acc_round_clamp_lane.sv
module acc_round_clamp_lane
    import acc_round_clamp_pkg::*;
#(
    parameter int EW = 8,
    localparam int WW  = 2 * EW,
    localparam int WAW = 3 * WW
) (
    input  logic [WAW-1:0] acc_i,
    input  logic [WW-1:0]  sh_i,
    input  rnd_rule_e      rule_i,
    input  logic           sclamp_i,
    input  logic           narrow_i,
    output logic [WW-1:0]  res_o
);

    localparam int NAW = 3 * EW;
    localparam int SAW = $clog2(WAW);
    localparam int MW  = WAW + 1;
    localparam int RW  = MW + 1;

    localparam logic signed [RW-1:0] N_SMAX = RW'((longint'(1) << (EW - 1)) - 1);
    localparam logic signed [RW-1:0] N_SMIN = RW'(-(longint'(1) << (EW - 1)));
    localparam logic signed [RW-1:0] N_UMAX = RW'((longint'(1) << EW) - 1);
    localparam logic signed [RW-1:0] W_SMAX = RW'((longint'(1) << (WW - 1)) - 1);
    localparam logic signed [RW-1:0] W_SMIN = RW'(-(longint'(1) << (WW - 1)));
    localparam logic signed [RW-1:0] W_UMAX = RW'((longint'(1) << WW) - 1);

    logic                 over;
    logic                 neg;
    logic [WW-1:0]        lim;
    logic [SAW-1:0]       sa;
    logic [MW-1:0]        ext;
    logic [MW-1:0]        mag;
    logic [MW-1:0]        q0;
    logic [MW-1:0]        mask;
    logic [MW-1:0]        rem;
    logic [MW-1:0]        half;
    logic [MW-1:0]        q;
    logic                 inc;
    logic signed [RW-1:0] r;
    logic signed [RW-1:0] hi;
    logic signed [RW-1:0] lo;
    logic signed [RW-1:0] c;

    // Range check on the shift amount.
    always_comb begin
        lim  = narrow_i ? WW'(NAW) : WW'(WAW);
        over = (sh_i >= lim);
        sa   = sh_i[SAW-1:0];
    end

    // Sign and magnitude.
    always_comb begin
        neg = acc_i[WAW-1];
        ext = {acc_i[WAW-1], acc_i};
        mag = neg ? (~ext + MW'(1)) : ext;
    end

    // Shift the magnitude, then round it.
    always_comb begin
        q0   = mag >> sa;
        mask = (MW'(1) << sa) - MW'(1);
        rem  = mag & mask;
        half = (sa == '0) ? '0 : (MW'(1) << (sa - SAW'(1)));
        inc  = 1'b0;
        if (sa != '0) begin
            unique case (rule_i)
                RND_TRUNC: inc = 1'b0;
                RND_AWAY:  inc = (rem >= half);
                RND_EVEN:  inc = (rem > half) || ((rem == half) && q0[0]);
                default:   inc = 1'b0;
            endcase
        end
        q = q0 + MW'(inc);
        r = neg ? -$signed({1'b0, q}) : $signed({1'b0, q});
    end

    // Saturate.
    always_comb begin
        if (sclamp_i) begin
            hi = narrow_i ? N_SMAX : W_SMAX;
            lo = narrow_i ? N_SMIN : W_SMIN;
        end else begin
            hi = narrow_i ? N_UMAX : W_UMAX;
            lo = '0;
        end
        if (r > hi)      c = hi;
        else if (r < lo) c = lo;
        else             c = r;
        if (over || (rule_i == RND_BAD)) res_o = '0;
        else if (narrow_i)               res_o = {{EW{1'b0}}, c[EW-1:0]};
        else                             res_o = c[WW-1:0];
    end

    always_comb begin
        if (over) begin
            AST_WIDE_SHIFT_ZERO: assert (res_o == '0); // R4
        end
        if (!over && (rule_i != RND_BAD) && sclamp_i && neg) begin
            AST_SIGN_KEPT: assert (narrow_i ? (res_o[EW-1] || (res_o[EW-1:0] == '0))
                                            : (res_o[WW-1] || (res_o == '0))); // R10
        end
    end

endmodule

// File: rtl/acc_round_clamp_ctrl.sv
module acc_round_clamp_ctrl
    import acc_round_clamp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic load_o,
    output logic valid_o
);

    emit_state_e st;
    emit_state_e st_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        unique case (st)
            ST_IDLE: st_nx = in_valid ? ST_EMIT : ST_IDLE;  // IDLE_TO_EMIT / IDLE_STAY
            ST_EMIT: st_nx = in_valid ? ST_EMIT : ST_IDLE;  // EMIT_STAY / EMIT_TO_IDLE
            default: st_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        load_o  = in_valid;
        valid_o = (st == ST_EMIT);
    end

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> valid_o); // R1
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !valid_o); // R1

endmodule

// File: rtl/acc_round_clamp.sv
module acc_round_clamp
    import acc_round_clamp_pkg::*;
#(
    parameter int LANES = 8,
    parameter int EW    = 8,
    localparam int WW   = 2 * EW,
    localparam int NAW  = 3 * EW,
    localparam int WAW  = 3 * WW,
    localparam int HL   = LANES / 2,
    localparam int ACCW = LANES * NAW,
    localparam int VW   = LANES * EW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            half_mode,
    input  logic [2:0]      rnd_mode,
    input  logic [ACCW-1:0] acc_in,
    input  logic [VW-1:0]   shamt_in,
    output logic            out_valid,
    output logic [VW-1:0]   res_out,
    output logic            bad_mode
);

    logic                    load;
    logic [LANES-1:0][WW-1:0] lane_res;
    logic [VW-1:0]           res_n;
    logic [VW-1:0]           res_w;
    logic [VW-1:0]           res_nx;
    logic                    bad_nx;
    rnd_rule_e               rule;

    assign rule = rnd_rule_e'(rnd_mode[1:0]);

    acc_round_clamp_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(in_valid),
        .load_o  (load),
        .valid_o (out_valid)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [WAW-1:0] acc_l;
        logic [WW-1:0]  sh_l;

        if (i < HL) begin : g_dual
            always_comb begin
                if (half_mode) begin
                    acc_l = acc_in[i*WAW +: WAW];
                    sh_l  = shamt_in[i*WW +: WW];
                end else begin
                    acc_l = {{(WAW-NAW){acc_in[i*NAW+NAW-1]}}, acc_in[i*NAW +: NAW]};
                    sh_l  = {{EW{1'b0}}, shamt_in[i*EW +: EW]};
                end
            end
            assign res_w[i*WW +: WW] = lane_res[i];
        end else begin : g_byte
            always_comb begin
                if (half_mode) begin
                    acc_l = '0;
                    sh_l  = '0;
                end else begin
                    acc_l = {{(WAW-NAW){acc_in[i*NAW+NAW-1]}}, acc_in[i*NAW +: NAW]};
                    sh_l  = {{EW{1'b0}}, shamt_in[i*EW +: EW]};
                end
            end
        end

        acc_round_clamp_lane #(.EW(EW)) u_lane (
            .acc_i   (acc_l),
            .sh_i    (sh_l),
            .rule_i  (rule),
            .sclamp_i(rnd_mode[2]),
            .narrow_i(~half_mode),
            .res_o   (lane_res[i])
        );

        assign res_n[i*EW +: EW] = lane_res[i][EW-1:0];
    end

    always_comb begin
        res_nx = half_mode ? res_w : res_n;
        bad_nx = (rule == RND_BAD);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_out  <= '0;
            bad_mode <= 1'b0;
        end else if (load) begin
            res_out  <= res_nx;
            bad_mode <= bad_nx;
        end
    end

    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(res_out)); // R1
    AST_BAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bad_mode |-> (res_out == '0)); // R11
    AST_BAD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (rnd_mode[1:0] == 2'b11)) |=> bad_mode); // R11

endmodule

// File: tb/acc_round_clamp_test.sv
`timescale 1ns/1ps
module acc_round_clamp_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         half_mode = 1'b0;
    logic [2:0]   rnd_mode = 3'd0;
    logic [191:0] acc_in = '0;
    logic [63:0]  shamt_in = '0;
    logic         out_valid;
    logic [63:0]  res_out;
    logic         bad_mode;

    int     n_chk = 0;
    int     n_err = 0;
    bit     finished = 1'b0;
    longint stim_acc [8];
    int     stim_sh  [8];
    longint rng = 64'h2545_f491_4f6c_dd1d;

    always #2 clk = ~clk;

    acc_round_clamp uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .half_mode(half_mode),
        .rnd_mode (rnd_mode),
        .acc_in   (acc_in),
        .shamt_in (shamt_in),
        .out_valid(out_valid),
        .res_out  (res_out),
        .bad_mode (bad_mode)
    );

    function automatic longint next_rand();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 7);
        rng = rng ^ (rng << 17);
        return rng;
    endfunction

    function automatic longint sx(longint v, int bits);
        longint m;
        longint sb;
        longint t;
        m  = (longint'(1) << bits) - 1;
        sb = longint'(1) << (bits - 1);
        t  = v & m;
        return (t ^ sb) - sb;
    endfunction

    // Arithmetic reference for one lane.
    function automatic longint ref_lane(longint acc, int s, int mode, bit h);
        int     lim;
        int     w;
        longint mag;
        longint d;
        longint q0;
        longint rem;
        longint q;
        longint v;
        longint hi;
        longint lo;
        lim = h ? 48 : 24;
        w   = h ? 16 : 8;
        if ((mode & 3) == 3) return 0;
        if (s >= lim) return 0;
        mag = (acc < 0) ? -acc : acc;
        if (s == 0) begin
            q = mag;
        end else begin
            d   = longint'(1) << s;
            q0  = mag / d;
            rem = mag % d;
            case (mode & 3)
                1:       q = q0 + ((2 * rem >= d) ? 1 : 0);
                2:       q = q0 + (((2 * rem > d) || ((2 * rem == d) && (q0 % 2 == 1))) ? 1 : 0);
                default: q = q0;
            endcase
        end
        v = (acc < 0) ? -q : q;
        if ((mode & 4) != 0) begin
            hi = (longint'(1) << (w - 1)) - 1;
            lo = -(longint'(1) << (w - 1));
        end else begin
            hi = (longint'(1) << w) - 1;
            lo = 0;
        end
        if (v > hi) v = hi;
        if (v < lo) v = lo;
        return v & ((longint'(1) << w) - 1);
    endfunction

    task automatic check(bit ok, string tag, longint got, longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s got %0h exp %0h", tag, got, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    function automatic longint make_acc(int i, int s, bit h, int p);
        int     w;
        int     ab;
        int     nb;
        longint v;
        longint k;
        w  = h ? 16 : 8;
        ab = h ? 48 : 24;
        case (p)
            0: v = next_rand();
            1: begin
                k = next_rand() & ((longint'(1) << (w + 1)) - 1);
                v = (k << s) + ((s > 0) ? (longint'(1) << (s - 1)) : 0);
                if ((next_rand() & 1) != 0) v = -v;
            end
            2: begin
                nb = s + w + 1;
                if (nb > 62) nb = 62;
                v = next_rand() & ((longint'(1) << nb) - 1);
                if ((next_rand() & 1) != 0) v = -v;
            end
            default: begin
                case (i % 4)
                    0: v = (longint'(1) << (ab - 1)) - 1;
                    1: v = -(longint'(1) << (ab - 1));
                    2: v = ((next_rand() & 1) != 0) ? 1 : -1;
                    default: v = 0;
                endcase
            end
        endcase
        return sx(v, ab);
    endfunction

    task automatic run_txn(bit h, int mode);
        int     nl;
        longint got;
        longint exp;
        string  tag;
        nl = h ? 4 : 8;
        @(negedge clk);
        half_mode = h;
        rnd_mode  = 3'(mode);
        acc_in    = '0;
        shamt_in  = '0;
        for (int i = 0; i < nl; i++) begin
            if (h) begin
                acc_in[i*48 +: 48]   = stim_acc[i][47:0];
                shamt_in[i*16 +: 16] = 16'(stim_sh[i]);
            end else begin
                acc_in[i*24 +: 24]  = stim_acc[i][23:0];
                shamt_in[i*8 +: 8]  = 8'(stim_sh[i]);
            end
        end
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b1, "R1 valid after request", longint'(out_valid), 1);
        check(bad_mode == ((mode & 3) == 3), "R11 invalid flag", longint'(bad_mode),
              longint'((mode & 3) == 3));
        for (int i = 0; i < nl; i++) begin
            got = h ? longint'(res_out[i*16 +: 16]) : longint'(res_out[i*8 +: 8]);
            exp = ref_lane(stim_acc[i], stim_sh[i], mode, h);
            tag = h ? "R3" : "R2";
            if ((mode & 3) == 3)                  tag = {tag, " R11"};
            else if (stim_sh[i] >= (h ? 48 : 24)) tag = {tag, " R4"};
            else if (stim_sh[i] == 0)             tag = {tag, " R5"};
            else if ((mode & 3) == 0)             tag = {tag, " R6"};
            else if ((mode & 3) == 1)             tag = {tag, " R7"};
            else                                  tag = {tag, " R8"};
            tag = {tag, ((mode & 4) != 0) ? " R10" : " R9"};
            check(got == exp, $sformatf("%s lane %0d acc %0d sh %0d mode %0d", tag, i,
                  stim_acc[i], stim_sh[i], mode), got, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [63:0] saved;
        int lim;
        repeat (3) @(negedge clk);
        // R12: reset state
        check(out_valid == 1'b0, "R12 valid in reset", longint'(out_valid), 0);
        check(res_out == '0, "R12 result in reset", longint'(res_out), 0);
        check(bad_mode == 1'b0, "R12 flag in reset", longint'(bad_mode), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 idle after reset", longint'(out_valid), 0);

        for (int h = 0; h < 2; h++) begin
            lim = (h != 0) ? 48 : 24;
            for (int mode = 0; mode < 8; mode++) begin
                for (int base = 0; base < lim + 2; base++) begin
                    for (int p = 0; p < 4; p++) begin
                        for (int i = 0; i < 8; i++) begin
                            stim_sh[i]  = (p == 1) ? base : (base + 3 * i) % (lim + 2);
                            stim_acc[i] = make_acc(i, stim_sh[i], bit'(h), p);
                        end
                        run_txn(bit'(h), mode);
                    end
                end
            end
        end

        // R1: result holds while no request is made
        for (int k = 0; k < 4; k++) begin
            for (int i = 0; i < 8; i++) begin
                stim_sh[i]  = i + k;
                stim_acc[i] = make_acc(i, stim_sh[i], 1'b0, 2);
            end
            run_txn(1'b0, 5);
            saved = res_out;
            acc_in   = {next_rand(), next_rand(), next_rand()};
            shamt_in = '0;
            rnd_mode = 3'd4;
            @(negedge clk);
            check(out_valid == 1'b0, "R1 no valid without request", longint'(out_valid), 0);
            check(res_out == saved, "R1 result held", longint'(res_out), longint'(saved));
        end

        summary();
    end

endmodule